// File: doc/BRIEF.md
# Event-Code Matched Delayed Trigger

This block watches a stream of event codes that arrives one code per event clock cycle and drives a bank of hardware trigger outputs. Each output channel holds four settings: the code it answers to, a delay, a pulse width and an enable. When an enabled channel sees its code, it counts out its delay and then holds its output high for its pulse width. Many channels can listen to the same stream, and each one keeps its own timing.

A simple write port sets the per-channel settings. Each write selects one channel and one field. The channel takes a copy of the delay and width when a hit arrives, so a later write never changes a pulse that is already scheduled. Code zero marks an empty cycle and never causes a hit.

Top module: `evtrig_top`

## Requirements
- R1: While reset is active, and after it is released, every trigger output is low and every channel is disabled with code, delay and width at zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the channel chosen by `cfg_ch`. The field is chosen by `cfg_field`: 0 is the match code (low CODE_W bits), 1 is the delay, 2 is the width and 3 is the enable (bit 0). The value is in force from the next clock edge, and a write to a channel index at or above NUM_CH is dropped.
- R3: A hit happens at a clock edge when the channel is enabled and idle, `evt_code` is nonzero, and `evt_code` equals the channel's code. An `evt_code` of zero never hits, even on a channel whose code is zero.
- R4: For a hit at edge k with delay D and width W (W nonzero), the output is high for exactly W cycles, starting right after edge k+D and ending after edge k+D+W-1.
- R5: A hit on a channel whose width is zero gives no pulse, and the channel stays idle, ready for the next hit.
- R6: The channel ignores hits at every edge from the hit edge k through edge k+D+W. The earliest hit it accepts again is at edge k+D+W+1.
- R7: Once a channel's enable is cleared, at the next edge its output goes low and any pending delay or pulse is dropped. While the channel is disabled, hits are ignored.
- R8: The delay and width used for a pulse are the values in force at its hit edge. A write in the same cycle as the hit, or any later write, does not change that pulse.
- R9: Channels run independently. Two channels with the same code both fire on one hit, each with its own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_code | input | CODE_W | Received event code, 0 = no event |
| cfg_we | input | 1 | Settings write strobe |
| cfg_ch | input | SEL_W | Channel selected by the write |
| cfg_field | input | 2 | Field selected: 0 code, 1 delay, 2 width, 3 enable |
| cfg_wdata | input | CNT_W | Write data |
| trig_out | output | NUM_CH | Trigger outputs, one per channel |

## Verification
The bench builds the block with four channels, 8-bit codes and 12-bit counters. The 12-bit counters put a full-scale delay and width of 4095 cycles each inside a short run, so the count boundaries are exercised at their limit and not only at small values. Four channels are enough for two channels to share one code, for a width-zero channel, and for a channel whose code is zero, all in the same stream. Random codes drawn mostly from the programmed set keep re-trigger, disable and mid-flight writes frequent.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

   // Field selector of the settings write port
   typedef enum logic [1:0] {
      FLD_CODE   = 2'd0,
      FLD_DELAY  = 2'd1,
      FLD_WIDTH  = 2'd2,
      FLD_ENABLE = 2'd3
   } cfg_field_e;

   // Per-channel sequencing state
   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_WAIT = 2'd1,
      CH_FIRE = 2'd2
   } ch_state_e;

endpackage

// File: rtl/evtrig_cfg.sv
module evtrig_cfg
   import evtrig_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 8,
   parameter int CNT_W  = 32,
   parameter int SEL_W  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [SEL_W-1:0]               cfg_ch,
   input  logic [1:0]                     cfg_field,
   input  logic [CNT_W-1:0]               cfg_wdata,
   output logic [NUM_CH-1:0][CODE_W-1:0]  ch_code,
   output logic [NUM_CH-1:0][CNT_W-1:0]   ch_delay,
   output logic [NUM_CH-1:0][CNT_W-1:0]   ch_width,
   output logic [NUM_CH-1:0]              ch_en
);

   cfg_field_e fld;
   assign fld = cfg_field_e'(cfg_field);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
      logic              sel;
      logic [CODE_W-1:0] code_q;
      logic [CNT_W-1:0]  delay_q;
      logic [CNT_W-1:0]  width_q;
      logic              en_q;

      assign sel = cfg_we && (cfg_ch == SEL_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q  <= '0;
            delay_q <= '0;
            width_q <= '0;
            en_q    <= 1'b0;
         end else if (sel) begin
            case (fld)
               FLD_CODE:   code_q  <= cfg_wdata[CODE_W-1:0];
               FLD_DELAY:  delay_q <= cfg_wdata;
               FLD_WIDTH:  width_q <= cfg_wdata;
               FLD_ENABLE: en_q    <= cfg_wdata[0];
               default:    ;
            endcase
         end
      end

      assign ch_code[c]  = code_q;
      assign ch_delay[c] = delay_q;
      assign ch_width[c] = width_q;
      assign ch_en[c]    = en_q;
   end

endmodule

// File: rtl/evtrig_chan.sv
module evtrig_chan
   import evtrig_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] evt_code,
   input  logic [CODE_W-1:0] match_code,
   input  logic [CNT_W-1:0]  delay,
   input  logic [CNT_W-1:0]  width,
   input  logic              en,
   output logic              trig,
   output logic              busy
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   ch_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] wlat;
   logic             hit;
   logic             cnt_done;

   assign hit      = en && (state == CH_IDLE) && (evt_code != '0) && (evt_code == match_code);
   assign cnt_done = (cnt == '0);
   assign busy     = (state != CH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CH_IDLE;
         cnt   <= '0;
         wlat  <= '0;
         trig  <= 1'b0;
      end else if (!en) begin
         state <= CH_IDLE;
         cnt   <= '0;
         trig  <= 1'b0;
      end else begin
         case (state)
            CH_IDLE: begin
               if (hit && (width != '0)) begin
                  wlat <= width;
                  if (delay == '0) begin
                     state <= CH_FIRE;
                     cnt   <= width - ONE;
                     trig  <= 1'b1;
                  end else begin
                     state <= CH_WAIT;
                     cnt   <= delay - ONE;
                  end
               end
            end
            CH_WAIT: begin
               if (cnt_done) begin
                  state <= CH_FIRE;
                  cnt   <= wlat - ONE;
                  trig  <= 1'b1;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            CH_FIRE: begin
               if (cnt_done) begin
                  state <= CH_IDLE;
                  trig  <= 1'b0;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            default: begin
               state <= CH_IDLE;
               trig  <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/evtrig_top.sv
module evtrig_top
   import evtrig_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 8,
   parameter int CNT_W  = 32,
   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] evt_code,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_ch,
   input  logic [1:0]        cfg_field,
   input  logic [CNT_W-1:0]  cfg_wdata,
   output logic [NUM_CH-1:0] trig_out
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("evtrig_top: NUM_CH must be at least 1");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("evtrig_top: CODE_W must be at least 2");
   end
   if (CNT_W < CODE_W) begin : g_bad_cnt
      $error("evtrig_top: CNT_W must not be narrower than CODE_W");
   end

   logic [NUM_CH-1:0][CODE_W-1:0] ch_code;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_delay;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_width;
   logic [NUM_CH-1:0]             ch_en;
   logic [NUM_CH-1:0]             ch_busy;

   evtrig_cfg #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W),
      .CNT_W  (CNT_W),
      .SEL_W  (SEL_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_ch    (cfg_ch),
      .cfg_field (cfg_field),
      .cfg_wdata (cfg_wdata),
      .ch_code   (ch_code),
      .ch_delay  (ch_delay),
      .ch_width  (ch_width),
      .ch_en     (ch_en)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      evtrig_chan #(
         .CODE_W (CODE_W),
         .CNT_W  (CNT_W)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt_code   (evt_code),
         .match_code (ch_code[c]),
         .delay      (ch_delay[c]),
         .width      (ch_width[c]),
         .en         (ch_en[c]),
         .trig       (trig_out[c]),
         .busy       (ch_busy[c])
      );
   end

endmodule

// File: rtl/evtrig_chk.sv
module evtrig_chk
   import evtrig_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 8,
   parameter int CNT_W  = 32,
   parameter int SEL_W  = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [CODE_W-1:0]             evt_code,
   input logic                          cfg_we,
   input logic [SEL_W-1:0]              cfg_ch,
   input logic [1:0]                    cfg_field,
   input logic [CNT_W-1:0]              cfg_wdata,
   input logic [NUM_CH-1:0]             trig_out,
   input logic [NUM_CH-1:0][CODE_W-1:0] ch_code,
   input logic [NUM_CH-1:0][CNT_W-1:0]  ch_delay,
   input logic [NUM_CH-1:0][CNT_W-1:0]  ch_width,
   input logic [NUM_CH-1:0]             ch_en,
   input logic [NUM_CH-1:0]             ch_busy
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R2
      code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && (cfg_ch == SEL_W'(c)) && (cfg_field == FLD_CODE))
         |=> (ch_code[c] == $past(cfg_wdata[CODE_W-1:0])));

      // R7
      dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[c] |=> !trig_out[c]);

      // R3
      hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_busy[c]) |-> (($past(evt_code) != '0) && ($past(evt_code) == $past(ch_code[c]))));

      // R4
      fire_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_en[c] && !ch_busy[c] && (evt_code != '0) && (evt_code == ch_code[c])
          && (ch_width[c] != '0) && (ch_delay[c] == '0)) |=> trig_out[c]);

      // R5
      zero_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_busy[c] && (ch_width[c] == '0)) |=> !ch_busy[c]);
   end

endmodule

bind evtrig_top evtrig_chk #(
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W),
   .CNT_W  (CNT_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_code  (evt_code),
   .cfg_we    (cfg_we),
   .cfg_ch    (cfg_ch),
   .cfg_field (cfg_field),
   .cfg_wdata (cfg_wdata),
   .trig_out  (trig_out),
   .ch_code   (ch_code),
   .ch_delay  (ch_delay),
   .ch_width  (ch_width),
   .ch_en     (ch_en),
   .ch_busy   (ch_busy)
);

// File: tb/evtrig_top_tb.sv
module evtrig_top_tb;

   localparam int NCH = 4;
   localparam int CW  = 8;
   localparam int NW  = 12;
   localparam int SW  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] evt = '0;
   logic          we = 1'b0;
   logic [SW-1:0] wch = '0;
   logic [1:0]    wfld = '0;
   logic [NW-1:0] wdat = '0;
   logic [NCH-1:0] trig;

   always #5 clk = ~clk;

   evtrig_top #(.NUM_CH(NCH), .CODE_W(CW), .CNT_W(NW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_code  (evt),
      .cfg_we    (we),
      .cfg_ch    (wch),
      .cfg_field (wfld),
      .cfg_wdata (wdat),
      .trig_out  (trig)
   );

   int    total = 0;
   int    bad = 0;
   string tag = "R1";
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   int    cyc = 0;

   // expected-value model: one high window per channel
   logic [CW-1:0] m_code  [NCH];
   int            m_delay [NCH];
   int            m_width [NCH];
   bit            m_en    [NCH];
   int            m_start [NCH];
   int            m_stop  [NCH];
   int            m_lock  [NCH];

   function automatic bit exp_out(int ch);
      return (cyc >= m_start[ch]) && (cyc <= m_stop[ch]);
   endfunction

   function automatic bit is_hit(int ch, logic [CW-1:0] code);
      return m_en[ch] && (code != '0) && (code == m_code[ch]) && (cyc > m_lock[ch]);
   endfunction

   task automatic check(bit ok, string req, int ch, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s ch%0d act=%0d exp=%0d at cycle %0d", req, ch, act, exp, cyc);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc = 0;
         for (int i = 0; i < NCH; i++) begin
            m_code[i] = '0; m_delay[i] = 0; m_width[i] = 0; m_en[i] = 1'b0;
            m_start[i] = 1; m_stop[i] = 0; m_lock[i] = -1;
         end
      end else begin
         cyc++;
         for (int i = 0; i < NCH; i++) begin
            if (!m_en[i]) begin
               m_start[i] = 1; m_stop[i] = 0; m_lock[i] = -1;
            end else if (is_hit(i, evt) && (m_width[i] != 0)) begin
               m_start[i] = cyc + m_delay[i];
               m_stop[i]  = m_start[i] + m_width[i] - 1;
               m_lock[i]  = m_stop[i] + 1;
            end
         end
         if (we && (int'(wch) < NCH)) begin
            case (wfld)
               2'd0: m_code[wch]  = wdat[CW-1:0];
               2'd1: m_delay[wch] = int'(wdat);
               2'd2: m_width[wch] = int'(wdat);
               default: m_en[wch] = wdat[0];
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         for (int i = 0; i < NCH; i++)
            check(trig[i] == exp_out(i), tag, i, trig[i], exp_out(i));
      end
   end

   task automatic wr(int ch, int fld, int data);
      @(negedge clk);
      we = 1'b1; wch = SW'(ch); wfld = 2'(fld); wdat = NW'(data);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic send(int code);
      @(negedge clk);
      evt = CW'(code);
      @(negedge clk);
      evt = '0;
   endtask

   task automatic wr_hit(int ch, int fld, int data, int code);
      @(negedge clk);
      we = 1'b1; wch = SW'(ch); wfld = 2'(fld); wdat = NW'(data); evt = CW'(code);
      @(negedge clk);
      we = 1'b0; evt = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(int ch, int code, int d, int w, int en);
      wr(ch, 0, code); wr(ch, 1, d); wr(ch, 2, w); wr(ch, 3, en);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1357));
      // R1: outputs low during and after reset
      idle(3);
      check(trig == '0, "R1", 0, int'(trig), 0);
      rst_n = 1'b1;
      idle(2);
      check(trig == '0, "R1", 0, int'(trig), 0);
      cmp_on = 1'b1;
      tag = "R1"; send(8'h05); idle(3);

      // R2: fresh settings act at once; write to ch0 then hit next cycle
      tag = "R2";
      setup(0, 8'h05, 0, 1, 1);
      send(8'h05); idle(4);
      setup(1, 8'h05, 3, 4, 1);
      setup(2, 8'h09, 2, 0, 1);
      setup(3, 8'h00, 0, 2, 1);

      // R9: two channels on one code
      tag = "R9"; send(8'h05); idle(10);
      // R3: code zero never hits, mismatching code ignored
      tag = "R3"; send(8'h00); send(8'h07); idle(5);
      // R5: zero width gives nothing, channel still ready
      tag = "R5"; send(8'h09); idle(4);
      wr(2, 2, 2); send(8'h09); idle(6);
      // R6: re-trigger during delay and pulse, then at the boundary
      tag = "R6";
      send(8'h05); send(8'h05); send(8'h05); idle(1); send(8'h05); idle(8);
      for (int g = 0; g < 4; g++) begin
         send(8'h05); idle(g + 5);
      end
      idle(8);
      // R8: write in the hit cycle and during the delay
      tag = "R8";
      wr_hit(1, 1, 6, 8'h05); idle(12);
      send(8'h05); wr(1, 2, 1); wr(1, 1, 2); idle(14);
      // R7: disable during a pending delay, hit while disabled, re-enable
      tag = "R7";
      wr(1, 1, 5); send(8'h05); wr(1, 3, 0); idle(8);
      send(8'h05); idle(6);
      wr(1, 3, 1); send(8'h05); idle(10);
      // R4: smallest and full-scale timing
      tag = "R4";
      setup(3, 8'h21, 1, 1, 1); send(8'h21); idle(5);
      setup(3, 8'h21, 4095, 4095, 1); send(8'h21); idle(8200);
      // R2: write to a channel index with no channel is harmless (all indexes exist here)
      tag = "R2"; wr(3, 0, 8'h05); send(8'h05); idle(8);
      // random mix
      tag = "R9";
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         case ($urandom % 6)
            0, 1: evt = '0;
            2: evt = 8'h05;
            3: evt = 8'h09;
            4: evt = 8'h21;
            default: evt = CW'($urandom);
         endcase
         if (($urandom % 20) == 0) begin
            we = 1'b1;
            wch = SW'($urandom);
            wfld = 2'($urandom);
            case (wfld)
               2'd0: wdat = NW'(($urandom % 2) ? 8'h05 : 8'h09);
               2'd1: wdat = NW'($urandom % 20);
               2'd2: wdat = NW'($urandom % 12);
               default: wdat = NW'(($urandom % 5) != 0);
            endcase
         end else begin
            we = 1'b0;
         end
      end
      @(negedge clk);
      we = 1'b0; evt = '0;
      idle(60);
      finish_run();
   end

endmodule